// File: doc/BRIEF.md
# Phase-Gated Memory Address Decoder

This block turns the 16-bit address, the read/write line and the phase-2 clock of an 8-bit microprocessor bus into active-low strobes for the memory devices on that bus. The low 56K of the address space is read-write memory built from two 32K static RAM devices. Above it sit a reserved hole that nothing answers, one address that opens the video command/status register, and the top 4K, which is system ROM. The block is purely combinational and has no state.

The processor may drive stray values onto the bus while phase 2 is low. Every strobe is therefore gated by phase 2, so no device can be selected, written or read outside the high half of the cycle. The RAM write enable and output enable follow the read/write line, and only assert while a RAM device is selected. The number of RAM banks, their size and the boundaries of the map are parameters.

Top module: `phase_mem_decoder`

## Requirements
- R1: While `phi2` is 0, every output (`ram_cs_n`, `ram_we_n`, `ram_oe_n`, `rom_cs_n`, `vreg_cs_n`) is 1, whatever the address and `rw_n` are.
- R2: While `phi2` is 1, an address in 0x0000..0x7FFF drives `ram_cs_n[0]` to 0 and `ram_cs_n[1]` to 1.
- R3: While `phi2` is 1, an address in 0x8000..0xDFFF drives `ram_cs_n[1]` to 0 and `ram_cs_n[0]` to 1. Address bit 15 selects the bank.
- R4: An address in 0xE000..0xEFFE leaves every output at 1 for both values of `rw_n`.
- R5: While `phi2` is 1, address 0xEFFF drives `vreg_cs_n` to 0, and all other outputs stay at 1.
- R6: While `phi2` is 1, an address in 0xF000..0xFFFF drives `rom_cs_n` to 0 for reads and for writes, and all other outputs stay at 1.
- R7: `ram_we_n` is 0 exactly when `phi2` is 1, `rw_n` is 0 (write) and a RAM bank is selected. `ram_oe_n` is 0 exactly when `phi2` is 1, `rw_n` is 1 (read) and a RAM bank is selected.
- R8: At most one of `ram_cs_n[0]`, `ram_cs_n[1]`, `rom_cs_n` and `vreg_cs_n` is 0 at any time.
- R9: On the RAM boundary, 0xDFFF selects bank 1 and 0xE000 selects no RAM bank and asserts neither `ram_we_n` nor `ram_oe_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Bus address |
| rw_n | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Phase-2 clock; accesses happen only while it is 1 |
| ram_cs_n | output | 2 | Active-low chip select, one bit per 32K RAM bank |
| ram_we_n | output | 1 | Active-low RAM write enable |
| ram_oe_n | output | 1 | Active-low RAM output enable |
| rom_cs_n | output | 1 | Active-low system ROM select |
| vreg_cs_n | output | 1 | Active-low video command/status register select |

## Verification
The bench goes after the edges of the map. At 0xDFFF/0xE000, a decoder with an off-by-one limit would write into RAM one byte past its end. At 0xEFFE/0xEFFF, a decoder that widens the register slot would answer inside the reserved hole. At 0x7FFF/0x8000, a wrong bank bit would alias the two RAM devices. It also holds phase 2 low at addresses that would otherwise select something, to catch any select that escapes the gate and lets bus noise corrupt memory. A full sweep of every address in both directions checks that two devices never drive the bus together.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    // Decoded region of an address
    typedef enum logic [2:0] {
        RGN_RAM  = 3'd0,
        RGN_HOLE = 3'd1,
        RGN_VREG = 3'd2,
        RGN_ROM  = 3'd3
    } region_e;

    // Default memory map
    localparam int unsigned DEF_ADDR_W    = 16;
    localparam int unsigned DEF_BANK_AW   = 15;
    localparam int unsigned DEF_RAM_BANKS = 2;
    localparam int unsigned DEF_RAM_LAST  = 32'h0000_DFFF;
    localparam int unsigned DEF_VREG_ADDR = 32'h0000_EFFF;
    localparam int unsigned DEF_ROM_FIRST = 32'h0000_F000;

endpackage

// File: rtl/pmd_region_classify.sv
module pmd_region_classify
    import pmd_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned BANK_AW   = DEF_BANK_AW,
    parameter int unsigned RAM_BANKS = DEF_RAM_BANKS,
    parameter int unsigned RAM_LAST  = DEF_RAM_LAST,
    parameter int unsigned VREG_ADDR = DEF_VREG_ADDR,
    parameter int unsigned ROM_FIRST = DEF_ROM_FIRST,
    localparam int unsigned IDX_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  bank_idx
);

    logic [31:0] addr_w;
    logic [31:0] bank_full;

    assign addr_w    = 32'(addr);
    assign bank_full = addr_w >> BANK_AW;

    // Ordered checks: RAM first, then the single register, then ROM
    always_comb begin
        region = RGN_HOLE;
        if (addr_w <= RAM_LAST) begin
            region = RGN_RAM;
        end else if (addr_w == VREG_ADDR) begin
            region = RGN_VREG;
        end else if (addr_w >= ROM_FIRST) begin
            region = RGN_ROM;
        end
    end

    assign bank_idx = bank_full[IDX_W-1:0];

endmodule

// File: rtl/pmd_ram_strobe.sv
module pmd_ram_strobe
    import pmd_pkg::*;
#(
    parameter int unsigned RAM_BANKS = DEF_RAM_BANKS,
    localparam int unsigned IDX_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1
) (
    input  region_e              region,
    input  logic [IDX_W-1:0]     bank_idx,
    input  logic                 phi2,
    input  logic                 rw_n,
    output logic [RAM_BANKS-1:0] cs_n,
    output logic                 we_n,
    output logic                 oe_n
);

    typedef struct packed {
        logic [RAM_BANKS-1:0] cs_n;
        logic                 we_n;
        logic                 oe_n;
    } ram_strobe_t;

    ram_strobe_t strobe_d;
    logic        ram_open;

    assign ram_open = phi2 && (region == RGN_RAM);

    always_comb begin
        strobe_d.cs_n = '1;
        strobe_d.we_n = 1'b1;
        strobe_d.oe_n = 1'b1;
        if (ram_open) begin
            strobe_d.we_n = rw_n;
            strobe_d.oe_n = ~rw_n;
        end
    end

    // One select per bank
    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
        assign cs_n[b] = ~(ram_open && (bank_idx == IDX_W'(b)));
    end

    assign we_n = strobe_d.we_n;
    assign oe_n = strobe_d.oe_n;

endmodule

// File: rtl/pmd_periph_strobe.sv
module pmd_periph_strobe
    import pmd_pkg::*;
(
    input  region_e region,
    input  logic    phi2,
    output logic    rom_cs_n,
    output logic    vreg_cs_n
);

    typedef struct packed {
        logic rom_cs_n;
        logic vreg_cs_n;
    } periph_strobe_t;

    periph_strobe_t strobe_d;

    always_comb begin
        strobe_d.rom_cs_n  = 1'b1;
        strobe_d.vreg_cs_n = 1'b1;
        if (phi2) begin
            strobe_d.rom_cs_n  = (region != RGN_ROM);
            strobe_d.vreg_cs_n = (region != RGN_VREG);
        end
    end

    assign rom_cs_n  = strobe_d.rom_cs_n;
    assign vreg_cs_n = strobe_d.vreg_cs_n;

endmodule

// File: rtl/phase_mem_decoder.sv
module phase_mem_decoder
    import pmd_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned BANK_AW   = DEF_BANK_AW,
    parameter int unsigned RAM_BANKS = DEF_RAM_BANKS,
    parameter int unsigned RAM_LAST  = DEF_RAM_LAST,
    parameter int unsigned VREG_ADDR = DEF_VREG_ADDR,
    parameter int unsigned ROM_FIRST = DEF_ROM_FIRST
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rw_n,
    input  logic                 phi2,
    output logic [RAM_BANKS-1:0] ram_cs_n,
    output logic                 ram_we_n,
    output logic                 ram_oe_n,
    output logic                 rom_cs_n,
    output logic                 vreg_cs_n
);

    localparam int unsigned IDX_W = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1;

    region_e          region;
    logic [IDX_W-1:0] bank_idx;

    pmd_region_classify #(
        .ADDR_W   (ADDR_W),
        .BANK_AW  (BANK_AW),
        .RAM_BANKS(RAM_BANKS),
        .RAM_LAST (RAM_LAST),
        .VREG_ADDR(VREG_ADDR),
        .ROM_FIRST(ROM_FIRST)
    ) u_classify (
        .addr    (addr),
        .region  (region),
        .bank_idx(bank_idx)
    );

    pmd_ram_strobe #(
        .RAM_BANKS(RAM_BANKS)
    ) u_ram (
        .region  (region),
        .bank_idx(bank_idx),
        .phi2    (phi2),
        .rw_n    (rw_n),
        .cs_n    (ram_cs_n),
        .we_n    (ram_we_n),
        .oe_n    (ram_oe_n)
    );

    pmd_periph_strobe u_periph (
        .region   (region),
        .phi2     (phi2),
        .rom_cs_n (rom_cs_n),
        .vreg_cs_n(vreg_cs_n)
    );

endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned RAM_BANKS = 2
) (
    input logic [ADDR_W-1:0]    addr,
    input logic                 rw_n,
    input logic                 phi2,
    input logic [RAM_BANKS-1:0] ram_cs_n,
    input logic                 ram_we_n,
    input logic                 ram_oe_n,
    input logic                 rom_cs_n,
    input logic                 vreg_cs_n
);

    logic any_ram;
    assign any_ram = ~&ram_cs_n;

    always_comb begin
        if (!phi2) begin
            assert_phi2_low_idle_R1: assert (&ram_cs_n && ram_we_n && ram_oe_n && rom_cs_n && vreg_cs_n)
                else $error("select active while phi2 low");
        end
        if (addr >= ADDR_W'(16'hE000) && addr <= ADDR_W'(16'hEFFE)) begin
            assert_hole_silent_R4: assert (&ram_cs_n && ram_we_n && ram_oe_n && rom_cs_n && vreg_cs_n)
                else $error("select active in reserved hole");
        end
        if (!rom_cs_n) begin
            assert_rom_range_R6: assert (addr[ADDR_W-1 -: 4] == 4'hF && phi2)
                else $error("rom select outside rom range");
        end
        if (!ram_we_n) begin
            assert_we_qual_R7: assert (any_ram && !rw_n && phi2)
                else $error("write enable without ram write");
        end
        if (!ram_oe_n) begin
            assert_oe_qual_R7: assert (any_ram && rw_n && phi2)
                else $error("output enable without ram read");
        end
        assert_single_select_R8: assert ($onehot0({~ram_cs_n, ~rom_cs_n, ~vreg_cs_n}))
            else $error("more than one select active");
    end

endmodule

bind phase_mem_decoder pmd_checker #(
    .ADDR_W   (ADDR_W),
    .RAM_BANKS(RAM_BANKS)
) u_chk (
    .addr     (addr),
    .rw_n     (rw_n),
    .phi2     (phi2),
    .ram_cs_n (ram_cs_n),
    .ram_we_n (ram_we_n),
    .ram_oe_n (ram_oe_n),
    .rom_cs_n (rom_cs_n),
    .vreg_cs_n(vreg_cs_n)
);

// File: tb/phase_mem_decoder_tb.sv
module phase_mem_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rw_n = 1'b1;
    logic        phi2 = 1'b0;
    logic [1:0]  ram_cs_n;
    logic        ram_we_n, ram_oe_n, rom_cs_n, vreg_cs_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    phase_mem_decoder u_dut (
        .addr     (addr),
        .rw_n     (rw_n),
        .phi2     (phi2),
        .ram_cs_n (ram_cs_n),
        .ram_we_n (ram_we_n),
        .ram_oe_n (ram_oe_n),
        .rom_cs_n (rom_cs_n),
        .vreg_cs_n(vreg_cs_n)
    );

    // Packed view: {cs1, cs0, we, oe, rom, vreg}, all active-low
    function automatic logic [5:0] observed();
        return {ram_cs_n[1], ram_cs_n[0], ram_we_n, ram_oe_n, rom_cs_n, vreg_cs_n};
    endfunction

    // Expected outputs computed from the requirements
    function automatic logic [5:0] model(input logic [15:0] a, input logic r, input logic p);
        logic [5:0] e;
        e = 6'b111111;
        if (p) begin
            if (a <= 16'hDFFF) begin
                if (a[15]) e[5] = 1'b0; else e[4] = 1'b0;
                if (r) e[2] = 1'b0; else e[3] = 1'b0;
            end else if (a == 16'hEFFF) begin
                e[0] = 1'b0;
            end else if (a >= 16'hF000) begin
                e[1] = 1'b0;
            end
        end
        return e;
    endfunction

    function automatic string req_of(input logic [15:0] a, input logic p);
        if (!p)                  return "R1";
        if (a == 16'hDFFF || a == 16'hE000) return "R9";
        if (a <= 16'h7FFF)       return "R2";
        if (a <= 16'hDFFF)       return "R3";
        if (a == 16'hEFFF)       return "R5";
        if (a >= 16'hF000)       return "R6";
        return "R4";
    endfunction

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h rw_n=%b phi2=%b got=%b exp=%b", req, addr, rw_n, phi2, got, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic r, input logic p);
        addr = a; rw_n = r; phi2 = p;
        #2;
    endtask

    // {addr, rw_n, phi2, expected}
    localparam int NV = 18;
    localparam logic [23:0] VECS [0:NV-1] = '{
        {16'h0000, 1'b1, 1'b1, 6'b101011},
        {16'h0000, 1'b0, 1'b1, 6'b100111},
        {16'h7FFF, 1'b1, 1'b1, 6'b101011},
        {16'h8000, 1'b1, 1'b1, 6'b011011},
        {16'hDFFF, 1'b0, 1'b1, 6'b010111},
        {16'hDFFF, 1'b1, 1'b1, 6'b011011},
        {16'hE000, 1'b1, 1'b1, 6'b111111},
        {16'hE000, 1'b0, 1'b1, 6'b111111},
        {16'hEFFE, 1'b0, 1'b1, 6'b111111},
        {16'hEFFF, 1'b0, 1'b1, 6'b111110},
        {16'hEFFF, 1'b1, 1'b1, 6'b111110},
        {16'hF000, 1'b1, 1'b1, 6'b111101},
        {16'hFFFF, 1'b1, 1'b1, 6'b111101},
        {16'hFFFF, 1'b0, 1'b1, 6'b111101},
        {16'h0000, 1'b0, 1'b0, 6'b111111},
        {16'h9000, 1'b1, 1'b0, 6'b111111},
        {16'hEFFF, 1'b0, 1'b0, 6'b111111},
        {16'hFFFF, 1'b1, 1'b0, 6'b111111}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (2) @(negedge clk);
        // Idle state after reset: phi2 low, nothing selected (R1)
        #2;
        check("R1", observed(), 6'b111111);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][23:8], VECS[i][7], VECS[i][6]);
            check(req_of(VECS[i][23:8], VECS[i][6]), observed(), VECS[i][5:0]);
        end

        // Write/read strobes on RAM follow rw_n (R7)
        apply(16'h4000, 1'b0, 1'b1);
        check("R7", {ram_we_n, ram_oe_n}, 2'b01);
        apply(16'h4000, 1'b1, 1'b1);
        check("R7", {ram_we_n, ram_oe_n}, 2'b10);
        // Boundary one past RAM (R9)
        apply(16'hE000, 1'b0, 1'b1);
        check("R9", {ram_cs_n, ram_we_n, ram_oe_n}, 4'b1111);

        // Full sweep, both directions, phi2 high; then phase gating
        for (int a = 0; a < 65536; a++) begin
            for (int r = 0; r < 2; r++) begin
                apply(16'(a), r[0], 1'b1);
                check(req_of(16'(a), 1'b1), observed(), model(16'(a), r[0], 1'b1));
                check("R8", {5'b0, $countones(~{ram_cs_n, rom_cs_n, vreg_cs_n}) <= 1},
                      6'b000001);
            end
            if ((a % 97) == 0) begin
                apply(16'(a), 1'b0, 1'b0);
                check("R1", observed(), 6'b111111);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule